// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block provides a processor-style interval timer built from two 32-bit registers. The count register advances by one on every clock unless counting is disabled. The compare register holds a target value. When the count register holds the same value as the compare register, the block raises a timer interrupt. The interrupt is a level: it stays high until software writes the compare register or the block is reset.

Software can load either register at any time and can read both back. Writing the compare register is the way to acknowledge the interrupt. A 3-bit line-select input steers the interrupt onto one of eight bits of the interrupt vector. A release selector decides whether a separate timer-pending status bit is kept up to date: that bit follows the interrupt only when the selector reads 1, and holds its value for every other selector value.

Top module: `cmpcount_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count register becomes 1, the compare register becomes 0, and both `irq_vec` and `tmr_pend` become 0.
- R2: On each clock edge where `cnt_halt` is 0 and there is no count write, the count register increases by one. The value 0xFFFFFFFF wraps to 0.
- R3: A count write loads `cnt_wdata` at that edge, whether or not `cnt_halt` is set. On the following enabled edges counting continues from the loaded value.
- R4: While `cnt_halt` is 1, the count register holds its value unless it is written, and no new interrupt is raised.
- R5: If, at a clock edge, the count register equals the compare register, `cnt_halt` is 0 and there is no compare write, then the interrupt is high after that edge. It then stays high until a compare write or reset.
- R6: A compare write loads `cmp_wdata` and drops the interrupt at that edge. When a match and a compare write fall on the same edge, the interrupt ends low.
- R7: When `rel_sel` equals 1, `tmr_pend` is set on a match and cleared on a compare write, with clearing winning. For any other `rel_sel` value, `tmr_pend` keeps its value.
- R8: `irq_vec` bit number `line_sel` carries the interrupt, and every other bit is 0. Changing `line_sel` moves a pending interrupt to the new bit in the same cycle.
- R9: `cnt_rdata` and `cmp_rdata` always show the current count and compare register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 32 | Count write value |
| cmp_we | input | 1 | Compare register write strobe (also acknowledges the interrupt) |
| cmp_wdata | input | 32 | Compare write value |
| cnt_halt | input | 1 | Count disable |
| rel_sel | input | 3 | Architecture release selector |
| line_sel | input | 3 | Interrupt line select |
| cnt_rdata | output | 32 | Current count value |
| cmp_rdata | output | 32 | Current compare value |
| tmr_pend | output | 1 | Timer-pending status bit |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The bench sweeps all eight line selects against all eight release values, and it compares every output on every cycle against an arithmetic model.

It targets these corner cases:
- **Wrap-around.** A counter that stops at all-ones instead of wrapping would show up at the 0xFFFFFFFF step.
- **Compare write on a match edge.** A design that lets the set win would leave the interrupt stuck high.
- **Count loaded equal to compare while halted.** A design that ignores the halt would fire early.
- **Moving the line select while the interrupt is pending.** A latched route would leave the interrupt on the old bit.
- **Pending bit under release values other than 1.** A design that updates it there would clear or set a bit that must hold.

// File: rtl/cmpcount_pkg.sv
// Package: shared widths and defaults for the count/compare timer.
// Assumes a 32-bit data path and eight interrupt lines by default.
package cmpcount_pkg;
    localparam int unsigned TMR_W     = 32;
    localparam int unsigned TMR_LINES = 8;
    localparam int unsigned TMR_REL_W = 3;
    localparam int unsigned TMR_PEND_REL = 1;
endpackage

// File: rtl/cmpcount_counter.sv
// Module: cmpcount_counter
// Holds the free-running count register.
// A write always wins. Otherwise the count advances by one per clock unless halted.
// Assumes synchronous active-low reset.
module cmpcount_counter #(
    parameter int unsigned DATA_W = cmpcount_pkg::TMR_W,
    parameter logic [DATA_W-1:0] RESET_VAL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              halt,
    output logic [DATA_W-1:0] count
);
    localparam logic [DATA_W-1:0] STEP = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] count_q;

    // Count register: reset, load, hold or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= RESET_VAL;
        else if (wr_en)
            count_q <= wr_data;
        else if (!halt)
            count_q <= count_q + STEP;
    end

    assign count = count_q;

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !wr_en) |=> (count_q == $past(count_q) + STEP));
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count_q == $past(wr_data)));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> $stable(count_q));
endmodule

// File: rtl/cmpcount_match.sv
// Module: cmpcount_match
// Holds the compare register, the level interrupt and the release-gated pending bit.
// Assumes a compare write takes priority over a match on the same edge.
module cmpcount_match #(
    parameter int unsigned DATA_W   = cmpcount_pkg::TMR_W,
    parameter int unsigned REL_W    = cmpcount_pkg::TMR_REL_W,
    parameter int unsigned PEND_REL = cmpcount_pkg::TMR_PEND_REL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] cmp_wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              halt,
    input  logic [REL_W-1:0]  rel_sel,
    output logic [DATA_W-1:0] compare,
    output logic              irq,
    output logic              pend
);
    localparam logic [REL_W-1:0] REL_CODE = REL_W'(PEND_REL);

    logic [DATA_W-1:0] cmp_q;
    logic              irq_q;
    logic              pend_q;
    logic              hit;
    logic              rel_ok;

    // Match detect: equal values while counting is enabled.
    always_comb begin
        hit    = (count == cmp_q) && !halt;
        rel_ok = (rel_sel == REL_CODE);
    end

    // Compare register: reset to zero, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= cmp_wdata;
    end

    // Level interrupt: cleared by compare write, set by match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (cmp_we)
            irq_q <= 1'b0;
        else if (hit)
            irq_q <= 1'b1;
    end

    // Pending status bit: tracked only under the selected release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (rel_ok) begin
            if (cmp_we)
                pend_q <= 1'b0;
            else if (hit)
                pend_q <= 1'b1;
        end
    end

    assign compare = cmp_q;
    assign irq     = irq_q;
    assign pend    = pend_q;

    a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cmp_q && !halt && !cmp_we) |=> irq_q);
    a_r6_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !irq_q);
    a_r4_no_new_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !irq_q) |=> !irq_q);
    a_r7_pend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_sel != REL_CODE) |=> $stable(pend_q));
    a_r5_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !cmp_we) |=> irq_q);
endmodule

// File: rtl/cmpcount_route.sv
// Module: cmpcount_route
// Steers the single timer interrupt onto one bit of the interrupt vector.
// Purely combinational, so a change of select takes effect at once.
module cmpcount_route #(
    parameter int unsigned LINES = cmpcount_pkg::TMR_LINES,
    localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             irq_in,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] irq_vec
);
    // One decoder slice per interrupt line.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign irq_vec[i] = irq_in && (sel == SEL_W'(i));
    end

    always_comb begin
        a_r8_single_line: assert ($onehot0(irq_vec));
    end
endmodule

// File: rtl/cmpcount_timer.sv
// Module: cmpcount_timer (top)
// Count/compare interval timer with a routed level interrupt.
// Assumes a synchronous active-low reset and single-clock register writes.
module cmpcount_timer #(
    parameter int unsigned DATA_W   = cmpcount_pkg::TMR_W,
    parameter int unsigned LINES    = cmpcount_pkg::TMR_LINES,
    parameter int unsigned REL_W    = cmpcount_pkg::TMR_REL_W,
    parameter int unsigned PEND_REL = cmpcount_pkg::TMR_PEND_REL,
    localparam int unsigned SEL_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] cnt_wdata,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] cmp_wdata,
    input  logic              cnt_halt,
    input  logic [REL_W-1:0]  rel_sel,
    input  logic [SEL_W-1:0]  line_sel,
    output logic [DATA_W-1:0] cnt_rdata,
    output logic [DATA_W-1:0] cmp_rdata,
    output logic              tmr_pend,
    output logic [LINES-1:0]  irq_vec
);
    logic [DATA_W-1:0] count_w;
    logic              irq_w;

    cmpcount_counter #(.DATA_W(DATA_W), .RESET_VAL(DATA_W'(1))) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_we),
        .wr_data (cnt_wdata),
        .halt    (cnt_halt),
        .count   (count_w)
    );

    cmpcount_match #(.DATA_W(DATA_W), .REL_W(REL_W), .PEND_REL(PEND_REL)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .count     (count_w),
        .halt      (cnt_halt),
        .rel_sel   (rel_sel),
        .compare   (cmp_rdata),
        .irq       (irq_w),
        .pend      (tmr_pend)
    );

    cmpcount_route #(.LINES(LINES)) u_route (
        .irq_in  (irq_w),
        .sel     (line_sel),
        .irq_vec (irq_vec)
    );

    assign cnt_rdata = count_w;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cnt_rdata == DATA_W'(1) && cmp_rdata == '0 && irq_vec == '0 && !tmr_pend));
endmodule

// File: tb/sim_cmpcount_timer.sv
module sim_cmpcount_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_we = 1'b0;
    logic [31:0] cnt_wdata = '0;
    logic        cmp_we = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic        cnt_halt = 1'b0;
    logic [2:0]  rel_sel = '0;
    logic [2:0]  line_sel = '0;
    logic [31:0] cnt_rdata;
    logic [31:0] cmp_rdata;
    logic        tmr_pend;
    logic [7:0]  irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench-side model state
    logic [31:0] m_cnt;
    logic [31:0] m_cmp;
    logic        m_irq;
    logic        m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpcount_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cnt_halt(cnt_halt),
        .rel_sel(rel_sel), .line_sel(line_sel), .cnt_rdata(cnt_rdata),
        .cmp_rdata(cmp_rdata), .tmr_pend(tmr_pend), .irq_vec(irq_vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_vec();
        return m_irq ? (8'd1 << line_sel) : 8'd0;
    endfunction

    task automatic check_all();
        check("R9 count read", cnt_rdata, m_cnt);
        check("R9 compare read", cmp_rdata, m_cmp);
        check("R5 irq level", {31'd0, |irq_vec}, {31'd0, m_irq});
        check("R7 pending bit", {31'd0, tmr_pend}, {31'd0, m_pend});
        check("R8 line routing", {24'd0, irq_vec}, {24'd0, exp_vec()});
    endtask

    // One clock: advance the model per the requirements, then compare.
    task automatic tick();
        logic hit;
        hit = (m_cnt == m_cmp) && !cnt_halt;
        if (rel_sel == 3'd1) begin
            if (cmp_we) m_pend = 1'b0;
            else if (hit) m_pend = 1'b1;
        end
        if (cmp_we) m_irq = 1'b0;
        else if (hit) m_irq = 1'b1;
        if (cnt_we) m_cnt = cnt_wdata;
        else if (!cnt_halt) m_cnt = m_cnt + 32'd1;
        if (cmp_we) m_cmp = cmp_wdata;
        @(posedge clk);
        #(CLK_PERIOD/4);
        cnt_we = 1'b0;
        cmp_we = 1'b0;
        check_all();
    endtask

    task automatic wr_cnt(input logic [31:0] v);
        cnt_we = 1'b1; cnt_wdata = v; tick();
    endtask

    task automatic wr_cmp(input logic [31:0] v);
        cmp_we = 1'b1; cmp_wdata = v; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset values
        check("R1 count reset", cnt_rdata, 32'd1);
        check("R1 compare reset", cmp_rdata, 32'd0);
        check("R1 irq reset", {24'd0, irq_vec}, 32'd0);
        check("R1 pend reset", {31'd0, tmr_pend}, 32'd0);
        m_cnt = 32'd1; m_cmp = 32'd0; m_irq = 1'b0; m_pend = 1'b0;
        rst_n = 1'b1;
        // R2: plain increment
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R2 increment", cnt_rdata, 32'd2 + k);
        end
        // R2/R3: wrap from all ones
        wr_cnt(32'hFFFF_FFFE);
        check("R3 load", cnt_rdata, 32'hFFFF_FFFE);
        tick();
        tick();
        check("R2 wrap to zero", cnt_rdata, 32'd0);
        // sweep every line against every release value
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 8; r++) begin
                rel_sel = 3'(r);
                line_sel = 3'(s);
                wr_cmp(32'd40 + 32'(s));
                check("R6 write acks irq", {24'd0, irq_vec}, 32'd0);
                wr_cnt(32'd37 + 32'(s));
                for (int k = 0; k < 5; k++) tick();
                check("R5 irq raised", {24'd0, irq_vec}, 32'd1 << s);
                line_sel = 3'(s + 1);
                #1;
                check("R8 moves with select", {24'd0, irq_vec}, 32'd1 << ((s + 1) % 8));
                tick();
                // R6: compare write on the edge that also matches
                wr_cmp(32'd200);
                wr_cnt(32'd200);
                cmp_we = 1'b1; cmp_wdata = 32'd500;
                tick();
                check("R6 clear beats match", {24'd0, irq_vec}, 32'd0);
                // R4: halted while equal raises nothing
                cnt_halt = 1'b1;
                wr_cnt(32'd500);
                for (int k = 0; k < 3; k++) tick();
                check("R4 held", cnt_rdata, 32'd500);
                check("R4 no irq", {24'd0, irq_vec}, 32'd0);
                cnt_halt = 1'b0;
                tick();
                tick();
                check("R4 fires once enabled", {31'd0, |irq_vec}, 32'd1);
                if (r != 1) check("R7 pend untouched", {31'd0, tmr_pend}, {31'd0, m_pend});
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule